// File: doc/BRIEF.md
# Receive FIFO Flow Control with Hysteresis Band

This block decides, once per clock, whether the remote transmitter should be told to pause. It watches the fill level of a receive FIFO and drives an active-low request-to-send style line, which can serve as either the RTS or the DTR output. The line goes high to stop the sender and low to let it resume. The high and low thresholds are placed around a programmed trigger level, and a selectable hysteresis band sets their distance from it.

A 4-bit hysteresis code picks one of fifteen band widths. The spacing of the widths is not linear. The code is honoured only when the trigger-table select equals the value for table D. In every other case, and when the code is zero, the block falls back to a two-level scheme. In that scheme the next higher FIFO trigger level sets the pause point and the programmed trigger level sets the resume point. The FIFO, the register decode and the serial receiver sit outside this block. They feed it levels and configuration.

Top module: `rxfc_hyst_rts`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rts_n` is 0 after that edge. The internal pause state is cleared.
- R2: The hysteresis code is used only when `table_sel` equals 2'b11. For any other `table_sel` value the block behaves exactly as if the code were 0.
- R3: Effective codes map to band widths in characters as follows: 1→4, 2→6, 3→8, 4→8, 5→16, 6→24, 7→32, 12→12, 13→20, 14→28, 15→36, 8→40, 9→44, 10→48, 11→52.
- R4: With a nonzero band and flow enabled, a `fill_lvl` of at least trigger plus band sets `rts_n` to 1 at the next clock edge.
- R5: With a nonzero band and flow enabled, a `fill_lvl` of at most trigger minus band (and no pause condition) sets `rts_n` to 0 at the next clock edge.
- R6: With flow enabled, a fill level that meets neither the pause condition nor the resume condition leaves `rts_n` unchanged.
- R7: With effective code 0, `rts_n` goes to 1 when `fill_lvl` is at least `trig_next`. It goes to 0 when `fill_lvl` is below `trig_lvl`.
- R8: Trigger plus band saturates at the FIFO depth (64). Trigger minus band saturates at 0, so a fill of 0 still resumes the sender.
- R9: With `flow_en` low, `rts_n` is 0 after the next edge and the pause state is cleared. After re-enabling, a fill level between the thresholds therefore gives 0.
- R10: When the pause and resume conditions are both true, the pause wins and `rts_n` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_en | input | 1 | Automatic flow control enable |
| table_sel | input | 2 | Trigger table select; 2'b11 enables the hysteresis code |
| hyst_code | input | 4 | Hysteresis band code |
| trig_lvl | input | 7 | Programmed receive trigger level (0..64) |
| trig_next | input | 7 | Next higher trigger level, used when the effective code is 0 |
| fill_lvl | input | 7 | Current receive FIFO count (0..64) |
| rts_n | output | 1 | Active-low request-to-send / data-terminal-ready line; 1 pauses the sender |

## Verification
The assertions assume that `fill_lvl`, `trig_lvl` and `trig_next` never exceed the FIFO depth. They also assume that all inputs are stable across each rising edge, because the thresholds are formed combinationally from them. The stimulus only drives values from 0 to 64 and changes them on the falling edge. The sweep over all codes uses a trigger of 30, so some upper thresholds clip at 64 and some lower thresholds clip at 0. One case deliberately sets `trig_next` below `trig_lvl` to check that pause takes priority.

// File: rtl/rxfc_pkg.sv
// Package: shared sizes and constants for the receive flow-control block.
// Assumes the FIFO depth fits a 7-bit count by default; widths derive from it.
package rxfc_pkg;
    localparam int FIFO_DEPTH = 64;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int CODE_W     = 4;
    localparam int SEL_W      = 2;
    localparam logic [SEL_W-1:0] SEL_TABLE_D = 2'b11;
endpackage

// File: rtl/rxfc_band_map.sv
// Module: rxfc_band_map
// Turns the hysteresis code into a band width in characters. It returns 0 when
// the table select is not table D or when the code is 0, and that 0 selects the
// next-trigger mode downstream.
// Assumes: the code is static or changes only between clock edges.
module rxfc_band_map #(
    parameter int CNT_W  = rxfc_pkg::CNT_W,
    parameter int CODE_W = rxfc_pkg::CODE_W,
    parameter int SEL_W  = rxfc_pkg::SEL_W
) (
    input  logic [SEL_W-1:0]  table_sel,
    input  logic [CODE_W-1:0] hyst_code,
    output logic [CNT_W-1:0]  band
);
    logic [CODE_W-1:0] eff_code;
    logic [7:0]        raw_band;

    // Gate the code with the table-D select.
    always_comb begin
        eff_code = (table_sel == rxfc_pkg::SEL_TABLE_D) ? hyst_code : '0;
    end

    // Non-linear lookup of the band width.
    always_comb begin
        unique case (eff_code)
            4'd1:    raw_band = 8'd4;
            4'd2:    raw_band = 8'd6;
            4'd3:    raw_band = 8'd8;
            4'd4:    raw_band = 8'd8;
            4'd5:    raw_band = 8'd16;
            4'd6:    raw_band = 8'd24;
            4'd7:    raw_band = 8'd32;
            4'd8:    raw_band = 8'd40;
            4'd9:    raw_band = 8'd44;
            4'd10:   raw_band = 8'd48;
            4'd11:   raw_band = 8'd52;
            4'd12:   raw_band = 8'd12;
            4'd13:   raw_band = 8'd20;
            4'd14:   raw_band = 8'd28;
            4'd15:   raw_band = 8'd36;
            default: raw_band = 8'd0;
        endcase
    end

    // Fit the band to the count width.
    always_comb begin
        band = raw_band[CNT_W-1:0];
    end
endmodule

// File: rtl/rxfc_thresh.sv
// Module: rxfc_thresh
// Forms the pause threshold and the resume threshold. The sender is paused when
// the fill is at or above halt_thr and resumed when the fill is strictly below
// rel_thr. A zero band selects the next-trigger mode. All thresholds saturate to
// the range 0..DEPTH.
// Assumes: the trigger inputs lie in 0..DEPTH.
module rxfc_thresh #(
    parameter int DEPTH = rxfc_pkg::FIFO_DEPTH,
    parameter int CNT_W = rxfc_pkg::CNT_W
) (
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] trig_next,
    input  logic [CNT_W-1:0] band,
    output logic [CNT_W-1:0] halt_thr,
    output logic [CNT_W:0]   rel_thr
);
    localparam int SW = CNT_W + 1;
    localparam logic [SW-1:0] DEPTH_W = SW'(DEPTH);

    logic [SW-1:0] up_sum;
    logic [SW-1:0] nxt_w;
    logic          band_mode;

    // Widen the operands so the sums cannot wrap.
    always_comb begin
        up_sum    = {1'b0, trig_lvl} + {1'b0, band};
        nxt_w     = {1'b0, trig_next};
        band_mode = (band != '0);
    end

    // Pause threshold, clipped at the FIFO depth.
    always_comb begin
        if (band_mode) begin
            halt_thr = (up_sum > DEPTH_W) ? DEPTH_W[CNT_W-1:0] : up_sum[CNT_W-1:0];
        end else begin
            halt_thr = (nxt_w > DEPTH_W) ? DEPTH_W[CNT_W-1:0] : trig_next;
        end
    end

    // Resume threshold (strict-less form), clipped so that a fill of 0 resumes.
    always_comb begin
        if (band_mode) begin
            if (trig_lvl >= band) begin
                rel_thr = {1'b0, trig_lvl - band} + SW'(1);
            end else begin
                rel_thr = SW'(1);
            end
        end else begin
            rel_thr = {1'b0, trig_lvl};
        end
    end
endmodule

// File: rtl/rxfc_state.sv
// Module: rxfc_state
// Holds the pause state and drives the active-low line. A pause request wins
// over a resume request. Disabling flow control clears the state.
// Assumes: the thresholds are settled before each rising edge.
module rxfc_state #(
    parameter int CNT_W = rxfc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flow_en,
    input  logic [CNT_W-1:0] fill_lvl,
    input  logic [CNT_W-1:0] halt_thr,
    input  logic [CNT_W:0]   rel_thr,
    output logic             rts_n
);
    logic halt_req;
    logic rel_req;
    logic paused_q;

    // Compare the fill level against both thresholds.
    always_comb begin
        halt_req = (fill_lvl >= halt_thr);
        rel_req  = ({1'b0, fill_lvl} < rel_thr);
    end

    // Pause-state register with hysteresis hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !flow_en) begin
            paused_q <= 1'b0;
        end else if (halt_req) begin
            paused_q <= 1'b1;
        end else if (rel_req) begin
            paused_q <= 1'b0;
        end
    end

    // Output follows the state: high pauses the sender.
    always_comb begin
        rts_n = paused_q;
    end

    a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !rts_n);

    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !halt_req && !rel_req) |=> $stable(rts_n));

    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> !rts_n);
endmodule

// File: rtl/rxfc_hyst_rts.sv
// Module: rxfc_hyst_rts (top)
// Receive FIFO flow control with a selectable hysteresis band. The band map, the
// threshold former and the pause-state register are wired in series. The
// output has one cycle of latency from the inputs.
// Assumes: fill and trigger inputs lie in 0..FIFO depth and are stable at each edge.
module rxfc_hyst_rts #(
    parameter int DEPTH  = rxfc_pkg::FIFO_DEPTH,
    parameter int CNT_W  = rxfc_pkg::CNT_W,
    parameter int CODE_W = rxfc_pkg::CODE_W,
    parameter int SEL_W  = rxfc_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic [SEL_W-1:0]  table_sel,
    input  logic [CODE_W-1:0] hyst_code,
    input  logic [CNT_W-1:0]  trig_lvl,
    input  logic [CNT_W-1:0]  trig_next,
    input  logic [CNT_W-1:0]  fill_lvl,
    output logic              rts_n
);
    logic [CNT_W-1:0] band;
    logic [CNT_W-1:0] halt_thr;
    logic [CNT_W:0]   rel_thr;

    rxfc_band_map #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_map (
        .table_sel (table_sel),
        .hyst_code (hyst_code),
        .band      (band)
    );

    rxfc_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thr (
        .trig_lvl  (trig_lvl),
        .trig_next (trig_next),
        .band      (band),
        .halt_thr  (halt_thr),
        .rel_thr   (rel_thr)
    );

    rxfc_state #(.CNT_W(CNT_W)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .flow_en  (flow_en),
        .fill_lvl (fill_lvl),
        .halt_thr (halt_thr),
        .rel_thr  (rel_thr),
        .rts_n    (rts_n)
    );

    a_r2_table_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (table_sel != rxfc_pkg::SEL_TABLE_D) |-> (band == '0));

    a_r4_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && band != '0 && fill_lvl >= halt_thr) |=> rts_n);

    a_r5_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && fill_lvl < halt_thr && {1'b0, fill_lvl} < rel_thr) |=> !rts_n);

    a_r8_halt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        halt_thr <= CNT_W'(DEPTH));

    a_r8_rel_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (band != '0) |-> (rel_thr != '0));

    a_r10_pause_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && fill_lvl >= halt_thr && {1'b0, fill_lvl} < rel_thr) |=> rts_n);
endmodule

// File: tb/rxfc_hyst_rts_tb.sv
// Scoreboard bench: the driver pushes expected line values, the monitor pops them.
module rxfc_hyst_rts_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flow_en = 1'b0;
    logic [1:0] table_sel = 2'b00;
    logic [3:0] hyst_code = 4'd0;
    logic [6:0] trig_lvl = 7'd0;
    logic [6:0] trig_next = 7'd0;
    logic [6:0] fill_lvl = 7'd0;
    logic       rts_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit model_paused = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    rxfc_hyst_rts dut_i (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .table_sel(table_sel),
        .hyst_code(hyst_code), .trig_lvl(trig_lvl), .trig_next(trig_next),
        .fill_lvl(fill_lvl), .rts_n(rts_n)
    );

    function automatic int band_of(bit [1:0] ts, bit [3:0] c);
        if (ts != 2'b11) return 0;
        case (c)
            4'd1: return 4;   4'd2: return 6;   4'd3: return 8;   4'd4: return 8;
            4'd5: return 16;  4'd6: return 24;  4'd7: return 32;  4'd8: return 40;
            4'd9: return 44;  4'd10: return 48; 4'd11: return 52; 4'd12: return 12;
            4'd13: return 20; 4'd14: return 28; 4'd15: return 36;
            default: return 0;
        endcase
    endfunction

    task automatic drive(bit rst, bit en, bit [1:0] ts, bit [3:0] code,
                         int trig, int nxt, int fill, string tag);
        int b, hi, lo;
        bit pause, resume;
        @(negedge clk);
        rst_n = rst; flow_en = en; table_sel = ts; hyst_code = code;
        trig_lvl = 7'(trig); trig_next = 7'(nxt); fill_lvl = 7'(fill);
        b = band_of(ts, code);
        if (b != 0) begin
            hi = (trig + b > 64) ? 64 : trig + b;
            lo = (trig - b < 0) ? 0 : trig - b;
            pause = (fill >= hi);
            resume = (fill <= lo);
        end else begin
            hi = (nxt > 64) ? 64 : nxt;
            pause = (fill >= hi);
            resume = (fill < trig);
        end
        if (!rst || !en) model_paused = 1'b0;
        else if (pause) model_paused = 1'b1;
        else if (resume) model_paused = 1'b0;
        exp_q.push_back(model_paused);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the output just after each edge against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rts_n !== e) begin
                    failures++;
                    $display("FAIL %s: rts_n=%0b expected=%0b", t, rts_n, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int b, hi, lo;
        // R1: reset holds the line low
        drive(0, 1, 2'b11, 4'd1, 16, 24, 60, "R1");
        drive(0, 1, 2'b11, 4'd1, 16, 24, 60, "R1");
        // R4/R5/R6: band of 4 around trigger 16
        drive(1, 1, 2'b11, 4'd1, 16, 24, 19, "R6");
        drive(1, 1, 2'b11, 4'd1, 16, 24, 20, "R4");
        drive(1, 1, 2'b11, 4'd1, 16, 24, 15, "R6");
        drive(1, 1, 2'b11, 4'd1, 16, 24, 13, "R6");
        drive(1, 1, 2'b11, 4'd1, 16, 24, 12, "R5");
        // R3/R8: sweep every nonzero code around trigger 30
        for (int c = 1; c < 16; c++) begin
            b = band_of(2'b11, 4'(c));
            hi = (30 + b > 64) ? 64 : 30 + b;
            lo = (30 - b < 0) ? 0 : 30 - b;
            drive(1, 1, 2'b11, 4'(c), 30, 40, 0, "R3");
            drive(1, 1, 2'b11, 4'(c), 30, 40, hi - 1, "R3");
            drive(1, 1, 2'b11, 4'(c), 30, 40, hi, "R8");
            drive(1, 1, 2'b11, 4'(c), 30, 40, lo + 1, "R3");
            drive(1, 1, 2'b11, 4'(c), 30, 40, lo, "R8");
        end
        // R2: code 5 ignored outside table D, next-trigger mode applies
        drive(1, 1, 2'b01, 4'd5, 16, 24, 23, "R2");
        drive(1, 1, 2'b01, 4'd5, 16, 24, 24, "R2");
        drive(1, 1, 2'b01, 4'd5, 16, 24, 16, "R2");
        drive(1, 1, 2'b01, 4'd5, 16, 24, 15, "R2");
        drive(1, 1, 2'b10, 4'd9, 16, 24, 24, "R2");
        // R7: code zero in table D
        drive(1, 1, 2'b11, 4'd0, 32, 48, 47, "R7");
        drive(1, 1, 2'b11, 4'd0, 32, 48, 48, "R7");
        drive(1, 1, 2'b11, 4'd0, 32, 48, 32, "R7");
        drive(1, 1, 2'b11, 4'd0, 32, 48, 31, "R7");
        drive(1, 1, 2'b11, 4'd0, 0, 64, 0, "R7");
        drive(1, 1, 2'b11, 4'd0, 0, 64, 64, "R8");
        // R9: disable clears the pause state
        drive(1, 0, 2'b11, 4'd1, 16, 24, 64, "R9");
        drive(1, 0, 2'b11, 4'd1, 16, 24, 64, "R9");
        drive(1, 1, 2'b11, 4'd1, 16, 24, 16, "R9");
        // R10: pause wins over resume
        drive(1, 1, 2'b11, 4'd0, 20, 8, 10, "R10");
        drive(1, 1, 2'b11, 4'd0, 20, 8, 7, "R10");
        // R1: reset clears a pause
        drive(1, 1, 2'b11, 4'd1, 16, 24, 40, "R4");
        drive(0, 1, 2'b11, 4'd1, 16, 24, 40, "R1");
        drive(1, 1, 2'b11, 4'd1, 16, 24, 16, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule